// File: doc/BRIEF.md
# Pixel Mask and Alpha Blend Stage

This block is a two-stage pipelined filter for 16-bit RGB565 pixels. It sits between a frame-buffer read path and a display output. Pixels enter and leave through valid/ready handshakes. For each accepted pixel it can do two things. It can replace the pixel with a fixed substitute colour when the pixel equals a programmed key colour. It can also mix the pixel with a second colour using an 8-bit weight. That second colour comes either from a parallel memory stream that arrives beside each pixel or from a fixed colour input.

A 2-bit mode input selects the operation. Bit 0 enables keying and bit 1 enables blending. When both are set, the key test looks at the unmixed foreground pixel, and a keyed pixel skips the mix. All configuration inputs are sampled together with the pixel when it is accepted, so a configuration change affects only the pixels accepted after it. Back-pressure from the output travels upstream through the pipeline, and no pixel is ever lost or repeated.

Top module: `pix_mask_blend`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `mode` = 0, the output pixel equals the input foreground pixel, including when that pixel equals `key_color`.
- R3: With `mode` = 1, a foreground pixel equal to `key_color` is output as `subst_color`, and any other pixel is output unchanged.
- R4: With `mode` = 2, each channel (red in bits 15:11, green in bits 10:5, blue in bits 4:0) is output as round((a*fg + (255-a)*bg)/255), where a is `alpha`. The channels are computed independently, and no key test is applied.
- R5: When `bg_sel` = 0 the blend colour bg is `in_bg`. When `bg_sel` = 1 it is `fixed_bg`, and `in_bg` has no effect on the output.
- R6: With `mode` = 3, the key test is applied to the raw foreground pixel. A match outputs `subst_color`, and a non-match outputs the R4 blend.
- R7: `alpha` = 255 outputs the foreground unchanged, and `alpha` = 0 outputs the blend colour.
- R8: A pixel accepted in cycle n appears with `out_valid` high in cycle n+2 when `out_ready` is high. It is not visible in cycle n+1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pix` hold their values. Pixels leave in the order they were accepted, none is dropped and none is duplicated.
- R10: With both stages full and `out_ready` at 0, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | bit 0 enables key, bit 1 enables blend |
| bg_sel | input | 1 | 0: blend colour from stream, 1: from fixed_bg |
| alpha | input | 8 | Foreground weight |
| key_color | input | 16 | Colour to be suppressed |
| subst_color | input | 16 | Output colour for suppressed pixels |
| fixed_bg | input | 16 | Fixed blend colour |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_fg | input | 16 | Foreground pixel |
| in_bg | input | 16 | Streamed blend colour |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts pixel |
| out_pix | output | 16 | Result pixel |

## Verification
A table of vectors tries every mode, with foreground pixels that equal the key colour and pixels that differ from it in a single bit. This separates keying from pass-through and shows that blend-only mode ignores the key. The blend vectors use a saturated foreground against black, mid-range colours at uneven weights, and the weights 0 and 255. A wrong rounding, a swapped weight or a channel leaking into its neighbour each gives a different result. Some vectors repeat a case with `bg_sel` changed while `in_bg` holds a distinct colour, so an error in the source select is visible. Directed tests then cover the latency and a stall with two pixels held and a third one waiting, to check the order and the stable output.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int PIX_W   = 16;
  localparam int ALPHA_W = 8;
  localparam int NUM_CH  = 3;
  localparam int STAGES  = 2;

  typedef enum logic [1:0] {
    PMB_OFF   = 2'd0,
    PMB_KEY   = 2'd1,
    PMB_BLEND = 2'd2,
    PMB_BOTH  = 2'd3
  } pmb_mode_e;

  // channel 0 = blue, 1 = green, 2 = red
  function automatic int chan_w(input int ch);
    return (ch == 1) ? 6 : 5;
  endfunction

  function automatic int chan_lsb(input int ch);
    case (ch)
      0:       return 0;
      1:       return 5;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/pmb_pipe_ctrl.sv
module pmb_pipe_ctrl #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic [STAGES-1:0] load,
  output logic [STAGES-1:0] vld
);
  logic [STAGES-1:0] v;
  logic [STAGES-1:0] en;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == STAGES - 1) begin : g_last
        assign en[i] = !v[i] || out_ready;
      end else begin : g_mid
        assign en[i] = !v[i] || en[i+1];
      end
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst)        v[i] <= 1'b0;
          else if (en[i]) v[i] <= in_valid;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst)        v[i] <= 1'b0;
          else if (en[i]) v[i] <= v[i-1];
        end
      end
    end
  endgenerate

  assign in_ready = en[0];
  assign load     = en;
  assign vld      = v;

  // R9: a held output word is never lost while stalled
  p_no_drop_r9: assert property (@(posedge clk) disable iff (rst)
    v[STAGES-1] && !out_ready |=> v[STAGES-1]);

  // R10: refusing input only happens with a full pipeline
  p_stall_full_r10: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (&v) && !out_ready);
endmodule

// File: rtl/pmb_chan_blend.sv
module pmb_chan_blend #(
  parameter int W       = 5,
  parameter int ALPHA_W = 8
) (
  input  logic [W-1:0]       fg,
  input  logic [W-1:0]       bg,
  input  logic [ALPHA_W-1:0] alpha,
  output logic [W-1:0]       mix
);
  localparam int SW = W + ALPHA_W + 3;
  localparam logic [ALPHA_W-1:0] AMAX = {ALPHA_W{1'b1}};

  logic [SW-1:0] prod, biased, quot;

  // exact round-to-nearest of prod / AMAX via shift-and-add (AMAX = 2^8-1)
  always_comb begin
    prod   = SW'(alpha) * SW'(fg) + SW'(AMAX - alpha) * SW'(bg);
    biased = prod + SW'(1 << (ALPHA_W - 1));
    quot   = (biased + (biased >> ALPHA_W)) >> ALPHA_W;
    mix    = quot[W-1:0];
  end

  // R4: a weighted mean never leaves the interval of its operands
  always_comb begin
    p_mix_range_r4: assert (quot <= SW'((fg > bg) ? fg : bg) &&
                            quot >= SW'((fg < bg) ? fg : bg));
  end
endmodule

// File: rtl/pix_mask_blend.sv
module pix_mask_blend
  import pmb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               bg_sel,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic [PIX_W-1:0]   key_color,
  input  logic [PIX_W-1:0]   subst_color,
  input  logic [PIX_W-1:0]   fixed_bg,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_fg,
  input  logic [PIX_W-1:0]   in_bg,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_pix
);
  logic [STAGES-1:0] ld, vl;

  pmb_pipe_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .load(ld), .vld(vl)
  );

  // stage 1: capture pixel, chosen blend colour and decoded mode
  logic [PIX_W-1:0]   s1_fg, s1_bg, s1_sub;
  logic [ALPHA_W-1:0] s1_alpha;
  logic               s1_hit, s1_mix_en;
  pmb_mode_e          mode_e;

  assign mode_e = pmb_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (ld[0]) begin
      s1_fg     <= in_fg;
      s1_bg     <= bg_sel ? fixed_bg : in_bg;
      s1_sub    <= subst_color;
      s1_alpha  <= alpha;
      s1_hit    <= (mode_e == PMB_KEY || mode_e == PMB_BOTH) && (in_fg == key_color);
      s1_mix_en <= (mode_e == PMB_BLEND || mode_e == PMB_BOTH);
    end
  end

  // per-channel blend datapath
  logic [PIX_W-1:0] mixed;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int CW  = chan_w(c);
      localparam int LSB = chan_lsb(c);
      pmb_chan_blend #(.W(CW), .ALPHA_W(ALPHA_W)) u_blend (
        .fg   (s1_fg[LSB +: CW]),
        .bg   (s1_bg[LSB +: CW]),
        .alpha(s1_alpha),
        .mix  (mixed[LSB +: CW])
      );
    end
  endgenerate

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (ld[1]) begin
      if (s1_hit)         out_pix <= s1_sub;
      else if (s1_mix_en) out_pix <= mixed;
      else                out_pix <= s1_fg;
    end
  end

  assign out_valid = vl[1];

  // R1: nothing valid on the output right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R9: stalled output word keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R3 / R6: a keyed pixel reaches the output as the substitute colour
  p_key_subst_r3: assert property (@(posedge clk) disable iff (rst)
    $past(ld[1] && vl[0] && s1_hit) |-> out_pix == $past(s1_sub));

  // R2: with neither keying nor blending the foreground passes
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    $past(ld[1] && vl[0] && !s1_hit && !s1_mix_en) |-> out_pix == $past(s1_fg));

  // R8: an accepted pixel occupies stage 1 on the next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> vl[0]);
endmodule

// File: tb/pix_mask_blend_test.sv
module pix_mask_blend_test;
  localparam int NV = 13;
  localparam logic [15:0] KEY = 16'hF81F;
  localparam logic [15:0] SUB = 16'h1234;
  localparam logic [15:0] FIX = 16'h07E0;

  // {mode[2], bg_sel[1], alpha[8], fg[16], bg[16]}
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h80, 16'h1234, 16'hFFFF},  // R2 plain pass
    {2'd0, 1'b0, 8'h80, 16'hF81F, 16'h0000},  // R2 key colour passes
    {2'd1, 1'b0, 8'h80, 16'hF81F, 16'h0000},  // R3 key hit
    {2'd1, 1'b0, 8'h80, 16'hF81E, 16'h0000},  // R3 one-bit miss
    {2'd2, 1'b0, 8'h80, 16'hFFFF, 16'h0000},  // R4 white on black
    {2'd2, 1'b0, 8'h40, 16'h8410, 16'h1234},  // R4 uneven weight
    {2'd2, 1'b0, 8'hFF, 16'hABCD, 16'h5555},  // R7 full weight
    {2'd2, 1'b0, 8'h00, 16'hABCD, 16'h5555},  // R7 zero weight
    {2'd2, 1'b1, 8'h80, 16'hF800, 16'hFFFF},  // R5 fixed colour
    {2'd2, 1'b0, 8'h80, 16'hF81F, 16'h07E0},  // R4 no key test
    {2'd3, 1'b0, 8'h80, 16'hF81F, 16'h1111},  // R6 key wins
    {2'd3, 1'b1, 8'h33, 16'h1F00, 16'hFFFF},  // R6 miss then blend
    {2'd3, 1'b1, 8'h00, 16'h4321, 16'hAAAA}   // R5 zero weight gives fixed
  };
  localparam int VREQ [NV] = '{2, 2, 3, 3, 4, 4, 7, 7, 5, 4, 6, 6, 5};

  logic        clk = 0, rst = 1;
  logic [1:0]  mode = 0;
  logic        bg_sel = 0;
  logic [7:0]  alpha = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [15:0] in_fg = 0, in_bg = 0;
  logic        in_ready, out_valid;
  logic [15:0] out_pix;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pix_mask_blend uut (
    .clk(clk), .rst(rst), .mode(mode), .bg_sel(bg_sel), .alpha(alpha),
    .key_color(KEY), .subst_color(SUB), .fixed_bg(FIX),
    .in_valid(in_valid), .in_ready(in_ready), .in_fg(in_fg), .in_bg(in_bg),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  function automatic int ch_mix(input int a, input int f, input int b);
    return (a * f + (255 - a) * b + 127) / 255;
  endfunction

  function automatic logic [15:0] model(input logic [1:0] m, input logic s,
      input logic [7:0] a, input logic [15:0] f, input logic [15:0] b0);
    logic [15:0] b, r;
    b = s ? FIX : b0;
    if (m[0] && f == KEY) return SUB;
    if (!m[1]) return f;
    r[15:11] = 5'(ch_mix(a, f[15:11], b[15:11]));
    r[10:5]  = 6'(ch_mix(a, f[10:5],  b[10:5]));
    r[4:0]   = 5'(ch_mix(a, f[4:0],   b[4:0]));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 0);
    rst = 0;
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 in_ready", {31'd0, in_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      {mode, bg_sel, alpha, in_fg, in_bg} = VEC[i];
      in_valid = 1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
      in_bg = ~in_bg;  // later changes must not reach the accepted pixel
      check($sformatf("R8 not early vec %0d", i), {31'd0, out_valid}, 0);
      @(negedge clk);
      check($sformatf("R8 valid vec %0d", i), {31'd0, out_valid}, 1);
      check($sformatf("R%0d vec %0d", VREQ[i], i), {16'd0, out_pix},
            {16'd0, model(VEC[i][42:41], VEC[i][40], VEC[i][39:32],
                          VEC[i][31:16], VEC[i][15:0])});
    end
    @(negedge clk);

    // R9 / R10: stall with two pixels held and a third waiting
    mode = 0; out_ready = 0;
    in_valid = 1; in_fg = 16'hAAA1;
    @(posedge clk); @(negedge clk);
    in_fg = 16'hBBB2;
    @(posedge clk); @(negedge clk);
    in_fg = 16'hCCC3;
    check("R10 in_ready full", {31'd0, in_ready}, 0);
    check("R9 first out", {16'd0, out_pix}, 32'hAAA1);
    repeat (3) @(negedge clk);
    check("R9 valid held", {31'd0, out_valid}, 1);
    check("R9 pixel held", {16'd0, out_pix}, 32'hAAA1);
    check("R10 still blocked", {31'd0, in_ready}, 0);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check("R9 second in order", {16'd0, out_pix}, 32'hBBB2);
    @(negedge clk);
    check("R9 third in order", {16'd0, out_pix}, 32'hCCC3);
    check("R9 third valid", {31'd0, out_valid}, 1);
    @(negedge clk);
    check("R9 no duplicate", {31'd0, out_valid}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule